// File: doc/BRIEF.md
# Word-Wide Programmable ROM Model

This block is a synthesizable, clocked behavioural model of a 16-bit wide programmable read-only memory. It covers both the erasable variant and the one-time variant. Every cell starts at logic 1. A program operation can only pull bits down to 0. On the erasable variant a bulk erase returns every word to all ones. The model keeps a full-width address bus for decoding, but stores only a parameterized number of words. Addresses fold onto that storage modulo the depth.

The operating mode comes from four controls: chip enable and output enable (both active low), a flag for the programming supply, and a flag for identifier access. The identifier flag stands in for the high-voltage level on an address pin. The tri-state data bus is split into a data output and a drive flag. Whenever the bus would float, the drive flag is low and the data output is zero. A program pulse is chip enable held low while the supply is present and output enable is high. The write lands when chip enable returns high. It uses the address and data from the last cycle of the pulse.

Top module: `prom_model`

## Requirements
- R1: After reset every stored word reads as 16'hFFFF.
- R2: A committed write stores the old word ANDed with the write data, so no bit ever goes from 0 back to 1 through programming.
- R3: With the supply flag low, the identifier flag low, and both enables low, the output is driven with the word at address modulo DEPTH. Upper address bits only alias.
- R4: With the supply flag low, the output floats (drive flag 0, data 0) when chip enable is low and output enable is high, and also whenever chip enable is high.
- R5: A program pulse is one or more clock cycles with the supply flag high, chip enable low and output enable high. It commits at the first following clock edge that samples chip enable high. The commit uses the address and data of the pulse's last cycle. If chip enable stays low while another mode begins, the pulse is dropped without a write.
- R6: With the supply flag high, chip enable high and output enable low (verify), the stored word is driven.
- R7: With the supply flag high and both enables high, or with the supply flag high and both enables low, the output floats and nothing is written.
- R8: During a program pulse the output floats.
- R9: With the identifier flag high, the supply flag low and both enables low, the output is driven with 16'h0097 when address bit 0 is 0 and with 16'h0030 when it is 1. All other address bits are ignored. With the identifier flag high in any other combination, decoding is unchanged.
- R10: With ERASABLE=1, an erase request sampled at a clock edge sets every word to 16'hFFFF. It wins over a write commit at the same edge.
- R11: With ERASABLE=0 the erase request has no effect on stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous active-low reset; restores the blank state |
| addr_i | input | AW | Word address |
| data_i | input | DW | Write data for a program pulse |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_i | input | 1 | Programming supply present |
| sig_i | input | 1 | Identifier access request |
| erase_i | input | 1 | Bulk erase request |
| data_o | output | DW | Output data, zero when not driven |
| data_oe_o | output | 1 | Output drive flag |

## Verification
The hardest situations to reach are at the end of a program pulse. One is a pulse that is abandoned while chip enable is still low, which must write nothing. The other is a pulse whose final edge coincides with an erase request, where the erase must win. The stimulus reaches these by leaving the supply-flag window with chip enable held low, and by raising the erase request on the same cycle that chip enable returns high. It also stretches one pulse over several cycles with changing data to confirm the last values are used. An erasable instance and a one-time instance run side by side, so that a single erase cycle exercises R10 and R11 together.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [2:0] {
    M_STBY,
    M_READ,
    M_ODIS,
    M_PGM,
    M_VERIFY,
    M_INHIB,
    M_SIG
  } prom_mode_e;

  localparam logic [7:0] MFR_ID = 8'h97;
  localparam logic [7:0] DEV_ID = 8'h30;
endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
  import prom_pkg::*;
(
  input  logic       ce_ni,
  input  logic       oe_ni,
  input  logic       vpp_i,
  input  logic       sig_i,
  output prom_mode_e mode_o
);
  always_comb begin
    if (!vpp_i) begin
      if (ce_ni)       mode_o = M_STBY;
      else if (oe_ni)  mode_o = M_ODIS;
      else if (sig_i)  mode_o = M_SIG;
      else             mode_o = M_READ;
    end else begin
      if (!ce_ni && oe_ni)      mode_o = M_PGM;
      else if (ce_ni && !oe_ni) mode_o = M_VERIFY;
      else                      mode_o = M_INHIB;  // both high or both low
    end
  end
endmodule

// File: rtl/prom_pgm_ctl.sv
module prom_pgm_ctl #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pgm_i,
  input  logic          ce_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      armed_q <= pgm_i;
      if (pgm_i) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end

  // pulse ends on the chip-enable rising edge; any other exit drops it
  assign commit_o = armed_q & ce_ni;
endmodule

// File: rtl/prom_array.sv
module prom_array #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int DEPTH    = 64,
  parameter bit ERASABLE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          commit_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int            IW      = $clog2(DEPTH);
  localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;
  logic          erase_en;

  assign wr_idx = IW'(wr_addr_i % DEPTH_A);
  assign rd_idx = IW'(rd_addr_i % DEPTH_A);

  generate
    if (ERASABLE) begin : g_erase
      assign erase_en = erase_i;
    end else begin : g_otp
      assign erase_en = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      mem_q[wr_idx] <= mem_q[wr_idx] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx];
endmodule

// File: rtl/prom_model.sv
module prom_model
  import prom_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int DEPTH    = 64,
  parameter bit ERASABLE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          vpp_i,
  input  logic          sig_i,
  input  logic          erase_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  prom_mode_e    mode;
  logic          commit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] sig_word;

  prom_mode_dec u_dec (
    .ce_ni (ce_ni),
    .oe_ni (oe_ni),
    .vpp_i (vpp_i),
    .sig_i (sig_i),
    .mode_o(mode)
  );

  prom_pgm_ctl #(.AW(AW), .DW(DW)) u_pgm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pgm_i    (mode == M_PGM),
    .ce_ni    (ce_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .commit_o (commit),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  prom_array #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ERASABLE(ERASABLE)) u_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .erase_i  (erase_i),
    .commit_i (commit),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(addr_i),
    .rd_data_o(rd_data)
  );

  always_comb begin
    sig_word      = '0;
    sig_word[7:0] = addr_i[0] ? DEV_ID : MFR_ID;
  end

  always_comb begin
    unique case (mode)
      M_READ, M_VERIFY: begin data_oe_o = 1'b1; data_o = rd_data;  end
      M_SIG:            begin data_oe_o = 1'b1; data_o = sig_word; end
      default:          begin data_oe_o = 1'b0; data_o = '0;       end
    endcase
  end
endmodule

// File: rtl/prom_model_chk.sv
module prom_model_chk #(
  parameter int DW       = 16,
  parameter bit ERASABLE = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          addr0_i,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          vpp_i,
  input logic          sig_i,
  input logic          erase_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o
);
  logic rd_cond;
  assign rd_cond = !vpp_i && !ce_ni && !oe_ni && !sig_i;

  // R3
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cond |-> data_oe_o);

  // R4
  idle_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_i && (ce_ni || oe_ni)) |-> (!data_oe_o && data_o == '0));

  // R6
  verify_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_i && ce_ni && !oe_ni) |-> data_oe_o);

  // R7
  inhibit_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_i && (ce_ni == oe_ni)) |-> (!data_oe_o && data_o == '0));

  // R8
  pgm_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_i && !ce_ni && oe_ni) |-> !data_oe_o);

  // R9
  sig_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_i && !vpp_i && !ce_ni && !oe_ni) |->
      (data_oe_o && data_o == (addr0_i ? {{(DW-8){1'b0}}, 8'h30} : {{(DW-8){1'b0}}, 8'h97})));

  // R10
  erase_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ERASABLE && erase_i) |=> (!rd_cond || data_o == '1));
endmodule

bind prom_model prom_model_chk #(.DW(DW), .ERASABLE(ERASABLE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr0_i  (addr_i[0]),
  .ce_ni    (ce_ni),
  .oe_ni    (oe_ni),
  .vpp_i    (vpp_i),
  .sig_i    (sig_i),
  .erase_i  (erase_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o)
);

// File: tb/prom_model_tb.sv
module prom_model_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, sig = 1'b0, erase = 1'b0;
  logic [DW-1:0] dout, otp_dout;
  logic          doe, otp_doe;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_model #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ERASABLE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .ce_ni(ce_n),
    .oe_ni(oe_n), .vpp_i(vpp), .sig_i(sig), .erase_i(erase),
    .data_o(dout), .data_oe_o(doe));

  prom_model #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ERASABLE(1'b0)) u_otp (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .ce_ni(ce_n),
    .oe_ni(oe_n), .vpp_i(vpp), .sig_i(sig), .erase_i(erase),
    .data_o(otp_dout), .data_oe_o(otp_doe));

  // reference model
  logic [DW-1:0] ref_e [DEPTH];
  logic [DW-1:0] ref_o [DEPTH];
  bit            armed, pgm_now, do_commit;
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin ref_e[i] = '1; ref_o[i] = '1; end
      armed = 0;
    end else begin
      pgm_now   = vpp && !ce_n && oe_n;
      do_commit = armed && ce_n;
      if (erase) begin
        for (int i = 0; i < DEPTH; i++) ref_e[i] = '1;
      end else if (do_commit) begin
        ref_e[cap_a % DEPTH] = ref_e[cap_a % DEPTH] & cap_d;
      end
      if (do_commit) ref_o[cap_a % DEPTH] = ref_o[cap_a % DEPTH] & cap_d;
      armed = pgm_now;
      if (pgm_now) begin cap_a = addr; cap_d = din; end
    end
  end

  function automatic logic [DW:0] model_out(input logic [DW-1:0] word);
    if (!vpp) begin
      if (!ce_n && !oe_n) return sig ? {1'b1, (addr[0] ? 16'h0030 : 16'h0097)} : {1'b1, word};
      return '0;
    end
    if (ce_n && !oe_n) return {1'b1, word};
    return '0;
  endfunction

  function automatic string mode_tag();
    if (!vpp) begin
      if (ce_n || oe_n) return "R4";
      return sig ? "R9" : "R3";
    end
    if (!ce_n && oe_n) return "R8";
    if (ce_n && !oe_n) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mode_tag(), {doe, dout}, model_out(ref_e[addr % DEPTH]));
      chk({mode_tag(), "/R11"}, {otp_doe, otp_dout}, model_out(ref_o[addr % DEPTH]));
    end
  end

  task automatic drive(input bit c, input bit o, input bit v, input bit s,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = c; oe_n = o; vpp = v; sig = s; addr = a; din = d; erase = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic probe(input string tag, input logic [DW:0] exp_v);
    @(negedge clk); #1;
    chk(tag, {doe, dout}, exp_v);
  endtask

  task automatic probe_otp(input string tag, input logic [DW:0] exp_v);
    @(negedge clk); #1;
    chk(tag, {otp_doe, otp_dout}, exp_v);
  endtask

  task automatic pgm(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive(0, 1, 1, 0, a, d); step();
    drive(1, 1, 1, 0, a, d); step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    drive(1, 1, 0, 0, '0, '0);
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 blank state
    drive(0, 0, 0, 0, 18'd0, '0);  probe("R1", {1'b1, 16'hFFFF}); step();
    drive(0, 0, 0, 0, 18'd63, '0); probe("R1", {1'b1, 16'hFFFF}); step();
    // R4 output disable and standby
    drive(0, 1, 0, 0, 18'd5, '0);  probe("R4", '0); step();
    drive(1, 0, 0, 0, 18'd5, '0);  probe("R4", '0); step();

    // R5 / R6 / R3 program, verify, read, alias
    pgm(18'd5, 16'hA5F0);
    drive(1, 0, 1, 0, 18'd5, '0);  probe("R6", {1'b1, 16'hA5F0}); step();
    drive(0, 0, 0, 0, 18'd5, '0);  probe("R3", {1'b1, 16'hA5F0}); step();
    drive(0, 0, 0, 0, 18'd69, '0); probe("R3", {1'b1, 16'hA5F0}); step();
    drive(0, 0, 0, 0, 18'h20005, '0); probe("R3", {1'b1, 16'hA5F0}); step();

    // R2 only clears
    pgm(18'd5, 16'h0FFF);
    drive(0, 0, 0, 0, 18'd5, '0);  probe("R2", {1'b1, 16'h05F0}); step();
    pgm(18'd5, 16'hFFFF);
    drive(0, 0, 0, 0, 18'd5, '0);  probe("R2", {1'b1, 16'h05F0}); step();

    // R5 long pulse, last data wins; R8 float during pulse
    drive(0, 1, 1, 0, 18'd9, 16'h1234); step();
    drive(0, 1, 1, 0, 18'd9, 16'hFF00); probe("R8", '0); step();
    drive(1, 1, 1, 0, 18'd9, 16'h0000); step();
    drive(0, 0, 0, 0, 18'd9, '0);  probe("R5", {1'b1, 16'hFF00}); step();

    // R5 aborted pulse
    drive(0, 1, 1, 0, 18'd12, 16'h0000); step();
    drive(0, 0, 0, 0, 18'd12, 16'h0000); step();
    drive(1, 1, 0, 0, 18'd12, 16'h0000); step();
    drive(0, 0, 0, 0, 18'd12, '0); probe("R5", {1'b1, 16'hFFFF}); step();

    // R7 inhibit and both-low with supply
    drive(1, 1, 1, 0, 18'd20, 16'h0000); probe("R7", '0); step(); step();
    drive(0, 0, 1, 0, 18'd20, 16'h0000); probe("R7", '0); step();
    drive(1, 1, 1, 0, 18'd20, 16'h0000); step();
    drive(0, 0, 0, 0, 18'd20, '0); probe("R7", {1'b1, 16'hFFFF}); step();

    // R9 identifier codes
    drive(0, 0, 0, 1, 18'd0, '0);     probe("R9", {1'b1, 16'h0097}); step();
    drive(0, 0, 0, 1, 18'd1, '0);     probe("R9", {1'b1, 16'h0030}); step();
    drive(0, 0, 0, 1, 18'h3FFFF, '0); probe("R9", {1'b1, 16'h0030}); step();
    drive(0, 0, 0, 1, 18'h3FFFE, '0); probe("R9", {1'b1, 16'h0097}); step();
    drive(1, 0, 0, 1, 18'd0, '0);     probe("R9", '0); step();

    // R10 / R11 erase colliding with a commit
    drive(0, 1, 1, 0, 18'd3, 16'h0000); step();
    drive(1, 1, 1, 0, 18'd3, 16'h0000); erase = 1'b1; step();
    drive(0, 0, 0, 0, 18'd3, '0); probe("R10", {1'b1, 16'hFFFF});
    chk("R11", {otp_doe, otp_dout}, {1'b1, 16'h0000}); step();
    drive(0, 0, 0, 0, 18'd5, '0); probe("R10", {1'b1, 16'hFFFF}); step();
    drive(0, 0, 0, 0, 18'd5, '0); probe_otp("R11", {1'b1, 16'h05F0}); step();
    drive(0, 0, 0, 0, 18'd9, '0); probe_otp("R11", {1'b1, 16'hFF00}); step();

    drive(1, 1, 0, 0, '0, '0);
    step(); step();
    summary();
    $finish;
  end
endmodule